// File: doc/BRIEF.md
# Serial DAC Input Word Receiver

This block is the digital front end of a 10-bit serial-input digital-to-analog converter. A host drives a serial clock, a frame-sync line, an optional chip-select line and a data line. The block samples all four of them with a faster system clock and assembles a 16-bit word, most significant bit first. When the word is finished, it moves the converter code and two mode flags into an output latch. It pulses a one-cycle update strobe at the same moment.

The word holds a 10-bit code and two control flags. One flag selects the fast or slow settling mode and the other selects power-down. A frame starts on a falling edge of frame-sync. It commits after sixteen bits, or earlier if frame-sync rises first. Chip-select allows several receivers to share one serial bus. When it is tied low permanently, the block runs in three-wire mode.

Top module: `dac_word_rx`

## Requirements
- R1: After reset, dacCode, fastMode, powerDown and updateStb are all zero.
- R2: While csIn is low, a falling edge of fsIn starts a frame. Each later falling edge of sclkIn captures one dinIn bit, most significant first, into bit positions 15 down to 0 of the word. Word bits 11..2 appear on dacCode, with bit 11 as its MSB.
- R3: Once sixteen bits are captured, the next rising edge of sclkIn commits the word. updateStb is high for exactly one system-clock cycle for each commit. The latched outputs change only on a commit.
- R4: If fsIn rises after the sixteenth bit but before the next rising edge of sclkIn, that rise commits the full word.
- R5: If fsIn rises after k bits, with 1 <= k <= 15, the word commits left-aligned: the k received bits sit in positions 15 down to 16-k and the other positions read as zero. If fsIn rises after zero bits, nothing is committed.
- R6: Word bit 14 drives fastMode (1 = fast settling, 0 = slow).
- R7: Word bit 13 drives powerDown (1 = amplifiers off, 0 = normal).
- R8: Word bits 15, 12, 1 and 0 have no effect on any output.
- R9: While csIn is high, sclkIn and fsIn activity is ignored: no frame starts and no commit occurs.
- R10: A rise of csIn during a frame aborts it. There is no updateStb, and the outputs keep their previous values.
- R11: With csIn held low all the time (three-wire use), frames are received and committed as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial bit clock from the host |
| fsIn | input | 1 | Frame-sync; a falling edge opens a frame, a rising edge may close it |
| csIn | input | 1 | Active-low chip select |
| dinIn | input | 1 | Serial data, MSB first |
| dacCode | output | 10 | Latched converter code |
| fastMode | output | 1 | Latched settling-mode flag |
| powerDown | output | 1 | Latched power-down flag |
| updateStb | output | 1 | One-cycle pulse on every latch update |

## Verification
The assertions assume that every serial input stays at each level for at least two system-clock cycles. This keeps each edge, after the two-flop synchronizers, distinct from the edges next to it. They also assume that dinIn is settled before the falling edge of sclkIn that captures it. The stimulus meets both assumptions. It holds each serial clock phase for four system clocks and changes data only while sclkIn is high. It also leaves at least one full phase between a change of csIn or fsIn and the next serial clock edge. Random words and a random mix of three-wire and four-wire frames run alongside directed cases: early frame-sync closes, aborts, and traffic with chip select deasserted.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CODE_W     = 10;
  localparam int CODE_LSB   = 2;
  localparam int SPEED_POS  = 14;
  localparam int POWER_POS  = 13;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // order of the synchronized input vector
  localparam int SIG_DIN  = 0;
  localparam int SIG_CS   = 1;
  localparam int SIG_FS   = 2;
  localparam int SIG_SCLK = 3;
  localparam int SIG_N    = 4;

  typedef struct packed {
    logic             clear;
    logic             shift;
    logic             commit;
    logic [IDX_W-1:0] pos;
  } rxStrobes_t;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else if (g == 0) stage[g] <= asyncIn;
        else stage[g] <= stage[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dacrx_ctrl.sv
module dacrx_ctrl
  import dacrx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SIG_N-1:0] syncIn,
  output rxStrobes_t       strb
);
  logic [SIG_N-1:0] prevIn;
  logic             frameOn;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkFall, sclkRise, fsFall, fsRise, csHigh, full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  assign sclkFall = prevIn[SIG_SCLK] & ~syncIn[SIG_SCLK];
  assign sclkRise = ~prevIn[SIG_SCLK] & syncIn[SIG_SCLK];
  assign fsFall   = prevIn[SIG_FS] & ~syncIn[SIG_FS];
  assign fsRise   = ~prevIn[SIG_FS] & syncIn[SIG_FS];
  assign csHigh   = syncIn[SIG_CS];
  assign full     = (bitCnt == CNT_W'(FRAME_BITS));

  always_comb begin
    strb        = '0;
    strb.pos    = IDX_W'(FRAME_BITS - 1 - int'(bitCnt));
    if (!csHigh) begin
      if (fsFall) strb.clear = 1'b1;
      else if (frameOn) begin
        if (fsRise)                strb.commit = (bitCnt != '0);
        else if (full && sclkRise) strb.commit = 1'b1;
        else if (!full && sclkFall) strb.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOn <= 1'b0;
      bitCnt  <= '0;
    end else if (csHigh) begin
      frameOn <= 1'b0;
    end else if (strb.clear) begin
      frameOn <= 1'b1;
      bitCnt  <= '0;
    end else if (frameOn && (fsRise || strb.commit)) begin
      frameOn <= 1'b0;
    end else if (strb.shift) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS));

  a_r2_clear_zeroes_count: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (bitCnt == '0) && frameOn);

  a_r9_idle_when_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !frameOn);

  a_r5_no_empty_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> bitCnt != '0);
endmodule

// File: rtl/dacrx_dpath.sv
module dacrx_dpath
  import dacrx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinSync,
  input  rxStrobes_t        strb,
  output logic [CODE_W-1:0] dacCode,
  output logic              fastMode,
  output logic              powerDown,
  output logic              updateStb
);
  logic [FRAME_BITS-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameReg <= '0;
    else if (strb.clear) frameReg <= '0;
    else if (strb.shift) frameReg[strb.pos] <= dinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      fastMode  <= 1'b0;
      powerDown <= 1'b0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= strb.commit;
      if (strb.commit) begin
        dacCode   <= frameReg[CODE_LSB +: CODE_W];
        fastMode  <= frameReg[SPEED_POS];
        powerDown <= frameReg[POWER_POS];
      end
    end
  end

  a_r3_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacCode) && $stable(fastMode) && $stable(powerDown));

  a_r3_strobe_follows_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> updateStb);
endmodule

// File: rtl/dac_word_rx.sv
module dac_word_rx
  import dacrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              fsIn,
  input  logic              csIn,
  input  logic              dinIn,
  output logic [CODE_W-1:0] dacCode,
  output logic              fastMode,
  output logic              powerDown,
  output logic              updateStb
);
  logic [SIG_N-1:0] rawIn, syncIn;
  rxStrobes_t       strb;

  assign rawIn = {sclkIn, fsIn, csIn, dinIn};

  dacrx_sync #(.WIDTH(SIG_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  dacrx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .strb(strb)
  );

  dacrx_dpath i_dpath (
    .clk(clk), .rstN(rstN), .dinSync(syncIn[SIG_DIN]), .strb(strb),
    .dacCode(dacCode), .fastMode(fastMode), .powerDown(powerDown),
    .updateStb(updateStb)
  );
endmodule

// File: tb/test_dac_word_rx.sv
`timescale 1ns/1ps
module test_dac_word_rx;
  localparam time TCLK = 20ns;
  localparam int  HALF = 4;   // system clocks per serial clock phase

  logic clk = 1'b0, rstN = 1'b0;
  logic sclkIn = 1'b0, fsIn = 1'b1, csIn = 1'b1, dinIn = 1'b0;
  logic [9:0] dacCode;
  logic fastMode, powerDown, updateStb;

  int nChecks = 0, nFails = 0, pulses = 0;
  logic [9:0] expCode = '0;
  logic expFast = 1'b0, expPd = 1'b0;

  always #(TCLK/2) clk = ~clk;

  dac_word_rx i_dac_word_rx (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .csIn(csIn),
    .dinIn(dinIn), .dacCode(dacCode), .fastMode(fastMode),
    .powerDown(powerDown), .updateStb(updateStb)
  );

  always @(posedge clk) if (updateStb) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] leftAlign(input logic [15:0] w, input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[15-i] = 1'b1;
    return w & m;
  endfunction

  // mode 0: four-wire, 1: three-wire, 2: chip select held high
  // abortAt >= 0: raise chip select after that many bits
  task automatic sendFrame(input logic [15:0] w, input int nBits, input int mode,
                           input bit viaFs, input int abortAt, input string req);
    int p0 = pulses;
    bit upd;
    logic [15:0] eff;
    csIn = (mode == 2) ? 1'b1 : 1'b0;
    waitClk(2*HALF);
    fsIn = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      if (abortAt == i) break;
      sclkIn = 1'b1; dinIn = w[15-i];
      waitClk(HALF);
      sclkIn = 1'b0;
      waitClk(HALF);
    end
    if (abortAt >= 0) begin
      csIn = 1'b1;
      waitClk(HALF);
    end else if (nBits == 16 && !viaFs) begin
      sclkIn = 1'b1;
      waitClk(HALF);
      sclkIn = 1'b0;
    end
    fsIn = 1'b1;
    waitClk(12);
    if (mode == 0) csIn = 1'b1;
    waitClk(HALF);
    upd = (mode != 2) && (abortAt < 0) && (nBits > 0);
    if (upd) begin
      eff = leftAlign(w, nBits);
      expCode = eff[11:2]; expFast = eff[14]; expPd = eff[13];
    end
    chk({req, " pulses"}, pulses - p0, upd ? 1 : 0);
    chk({req, " code"}, int'(dacCode), int'(expCode));
    chk({req, " R6 fast"}, int'(fastMode), int'(expFast));
    chk({req, " R7 pd"}, int'(powerDown), int'(expPd));
  endtask

  initial begin
    #(TCLK * 200000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    waitClk(3);
    chk("R1 code", int'(dacCode), 0);
    chk("R1 flags", int'({fastMode, powerDown, updateStb}), 0);
    rstN = 1'b1;
    waitClk(4);
    chk("R1 after release", int'({dacCode, fastMode, powerDown}), 0);

    sendFrame(16'h6AB4, 16, 0, 1'b0, -1, "R2 R3 four-wire");
    sendFrame(16'h0FFC, 16, 0, 1'b1, -1, "R4 fs close");
    sendFrame(16'h4000, 16, 1, 1'b0, -1, "R6 R11 three-wire");
    sendFrame(16'h2000, 16, 1, 1'b1, -1, "R7 R11 three-wire fs");
    sendFrame(16'hFFFF, 7,  0, 1'b0, -1, "R5 early seven");
    sendFrame(16'hFFFF, 0,  0, 1'b0, -1, "R5 zero bits");
    sendFrame(16'hA5A5, 11, 1, 1'b0, -1, "R5 R11 early eleven");
    sendFrame(16'h1234, 16, 0, 1'b0, -1, "R2 base");
    sendFrame(16'h1234 ^ 16'h9003, 16, 0, 1'b0, -1, "R8 ignored bits");
    sendFrame(16'h7FFC, 16, 2, 1'b0, -1, "R9 cs high");
    sendFrame(16'h3FF0, 16, 0, 1'b0, 7,  "R10 abort");
    sendFrame(16'h0004, 16, 0, 1'b0, -1, "R2 code lsb");

    for (int k = 0; k < 40; k++) begin
      logic [15:0] w = 16'($urandom);
      int m = int'($urandom_range(0, 1));
      bit f = 1'($urandom_range(0, 1));
      sendFrame(w, 16, m, f, -1, "R2 R3 R11 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule